// File: doc/BRIEF.md
# Rotate, Mask and Shift Unit

This block is the bit-manipulation stage of a 64-bit integer datapath. One left rotator and one mask generator serve every operation. The operations are rotate-under-mask for words and doublewords, rotate-and-insert, logical shifts in both directions, arithmetic right shift with a carry flag, and sign-extend-word-then-shift-left. A decoder reads five mode flags and the mask fields of the instruction word. From these it works out the rotate count, how the source is prepared and the two mask boundaries. A merge stage then combines the rotated value, the mask and a fill value. The result and the carry are captured in one output register, so each operation appears at the ports one clock after it is presented.

The decoder sorts every operation into one of five kinds, in a fixed priority: OPK_SEXTSHL, OPK_ROTMASK, OPK_SRA, OPK_SHR and OPK_SHL. There are no stored states and no transitions between them. The kind depends only on the current inputs, and each cycle is independent of the ones before it.

Mask bounds use big-endian numbering, where position 0 is the most significant bit. In word mode the bounds are offset by 32, and the low word of the source is copied into both halves before rotating. This lets a wrapping mask (begin greater than end) produce the correct pattern.

Top module: `rms_unit`

## Requirements
- R1: result and carry_out are registered. The operation presented before a rising clock edge appears after that edge. While rst_n is low, both outputs are zero.
- R2: Word rotate-with-mask is selected by mode_word=1 with clr_msb_en=1 and clr_lsb_en=1. The word begin field is insn_word[10:6] and the word end field is insn_word[5:1]. Each field has 32 added to it. The source low word is rotated left by shamt[4:0] and copied into both halves. The mask is the set of positions from begin to end, or, when begin is greater than end, the positions at or after begin plus those at or before end.
- R3: In rotate-with-mask forms, result bits outside the mask come from op_ins.
- R4: The doubleword mask field is {insn_word[5], insn_word[10:6]}. With clr_msb_en only, this field is the mask begin and the end is 63. With clr_lsb_en only, this field is the mask end and the begin is 0. The rotate count is shamt[5:0].
- R5: Doubleword rotate with both clear flags set uses the field as the begin and 63 minus shamt[5:0] as the end. The mask wraps as in R2.
- R6: A logical left shift has all of clr_msb_en, clr_lsb_en, mode_arith, mode_right and sext_src low. In word mode the count is shamt[5:0]; the result is the low 32 bits shifted and zero-extended, and is zero for counts of 32 or more. In doubleword mode the count is all 7 bits, and the result is zero for counts of 64 or more.
- R7: A logical right shift (mode_right=1, mode_arith=0, no clear flags) follows the same count and zero rules as R6. In word mode the result is zero-extended.
- R8: An arithmetic right shift has mode_arith=1, with neither clear flag nor sext_src set. It fills vacated bits with the sign. The word form uses bit 31 as the sign and returns the sign-extended 32-bit result; counts of 32 or more return all sign bits. The doubleword form uses the 7-bit count; counts of 64 or more return all sign bits.
- R9: In arithmetic right shift, carry_out is 1 exactly when the source is negative and at least one 1 bit is shifted out. carry_out is 0 in every other mode.
- R10: With sext_src=1, the low 32 bits are sign-extended to 64 bits and then shifted left by shamt[5:0]. shamt[6] and the other mode flags have no effect.
- R11: op_ins has no effect on shifts or on the sign-extend shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_src | input | 64 | Source operand |
| op_ins | input | 64 | Insert operand for rotate-with-mask forms |
| shamt | input | 7 | Shift or rotate amount |
| insn_word | input | 32 | Instruction word carrying the mask fields |
| mode_word | input | 1 | 32-bit operation |
| mode_right | input | 1 | Shift right |
| mode_arith | input | 1 | Arithmetic right shift |
| clr_msb_en | input | 1 | Mask begins at the begin bound |
| clr_lsb_en | input | 1 | Mask ends at the end bound |
| sext_src | input | 1 | Sign-extend the low word, then shift left |
| result | output | 64 | Registered result |
| carry_out | output | 1 | Registered carry from arithmetic right shift |

## Verification
A wrong mode kind, rotate count or mask bound inside the unit shows up on result one clock after the operation is presented. It usually appears as a band of bits shifted by the error, or as a mask edge off by a position at the begin or end bound. A wrong word-lane flag corrupts either the upper half of result or the carry. The carry fault is seen only when a negative word source loses 1 bits, so those cases are driven on purpose. Because every cycle is independent, each bad decode stays confined to the single result it belongs to and can be traced to it.

// File: rtl/rms_pkg.sv
package rms_pkg;

    typedef enum logic [2:0] {
        OPK_ROTMASK,
        OPK_SHL,
        OPK_SHR,
        OPK_SRA,
        OPK_SEXTSHL
    } op_kind_e;

    typedef enum logic [1:0] {
        SRC_FULL,
        SRC_DUPWORD,
        SRC_SEXTWORD
    } src_sel_e;

endpackage

// File: rtl/rms_decode.sv
module rms_decode
    import rms_pkg::*;
#(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input  logic [$clog2(DW):0]   shamt,
    input  logic [IW-1:0]         insn_word,
    input  logic                  mode_word,
    input  logic                  mode_right,
    input  logic                  mode_arith,
    input  logic                  clr_msb_en,
    input  logic                  clr_lsb_en,
    input  logic                  sext_src,
    output op_kind_e              kind,
    output src_sel_e              src_sel,
    output logic [$clog2(DW)-1:0] rot_amt,
    output logic [$clog2(DW)-1:0] mask_beg,
    output logic [$clog2(DW)-1:0] mask_end,
    output logic                  mask_empty,
    output logic                  word_lane
);

    localparam int CW  = $clog2(DW);
    localparam int SW  = CW + 1;
    localparam int WFW = CW - 1;
    localparam logic [CW-1:0] HALF_POS = CW'(DW / 2);
    localparam logic [CW-1:0] LAST_POS = CW'(DW - 1);

    logic [WFW-1:0] fld_wbeg;
    logic [WFW-1:0] fld_wend;
    logic [CW-1:0]  fld_dw;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  cnt_neg;
    logic           over_w;
    logic           over_d;
    logic           over_sel;

    // mask fields: word begin/end, doubleword field with its top bit split off
    assign fld_wbeg = insn_word[2*CW-2:CW];
    assign fld_wend = insn_word[CW-1:1];
    assign fld_dw   = {insn_word[CW-1], fld_wbeg};

    assign cnt      = shamt[CW-1:0];
    assign cnt_neg  = ~cnt + CW'(1);
    assign over_w   = cnt[CW-1];
    assign over_d   = shamt[SW-1];
    assign over_sel = mode_word ? over_w : over_d;

    assign word_lane = mode_word && !sext_src;

    // mode priority: sign-extend, then masked rotate, then arithmetic, right, left
    always_comb begin
        if (sext_src)
            kind = OPK_SEXTSHL;
        else if (clr_msb_en || clr_lsb_en)
            kind = OPK_ROTMASK;
        else if (mode_arith)
            kind = OPK_SRA;
        else if (mode_right)
            kind = OPK_SHR;
        else
            kind = OPK_SHL;
    end

    always_comb begin
        if (sext_src)
            src_sel = SRC_SEXTWORD;
        else if (mode_word)
            src_sel = SRC_DUPWORD;
        else
            src_sel = SRC_FULL;
    end

    always_comb begin
        rot_amt    = cnt;
        mask_beg   = '0;
        mask_end   = LAST_POS;
        mask_empty = 1'b0;
        unique case (kind)
            OPK_ROTMASK: begin
                if (clr_msb_en)
                    mask_beg = mode_word ? {1'b1, fld_wbeg} : fld_dw;
                else
                    mask_beg = mode_word ? HALF_POS : '0;
                if (clr_lsb_en) begin
                    if (mode_word)
                        mask_end = {1'b1, fld_wend};
                    else if (clr_msb_en)
                        mask_end = ~cnt;
                    else
                        mask_end = fld_dw;
                end
            end
            OPK_SHL: begin
                mask_beg   = mode_word ? HALF_POS : '0;
                mask_end   = ~cnt;
                mask_empty = over_sel;
            end
            OPK_SHR, OPK_SRA: begin
                rot_amt    = cnt_neg;
                mask_beg   = mode_word ? {1'b1, cnt[WFW-1:0]} : cnt;
                mask_empty = over_sel;
            end
            OPK_SEXTSHL: begin
                mask_end = ~cnt;
            end
            default: begin
                mask_empty = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rms_rotl.sv
module rms_rotl #(
    parameter int DW = 64
) (
    input  logic [DW-1:0]         din,
    input  logic [$clog2(DW)-1:0] amt,
    output logic [DW-1:0]         dout
);

    localparam int CW = $clog2(DW);

    logic [DW-1:0] stage [CW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s]
            ? {stage[s][DW-1-STEP:0], stage[s][DW-1 -: STEP]}
            : stage[s];
    end

    assign dout = stage[CW];

endmodule

// File: rtl/rms_maskgen.sv
module rms_maskgen #(
    parameter int DW = 64
) (
    input  logic [$clog2(DW)-1:0] mask_beg,
    input  logic [$clog2(DW)-1:0] mask_end,
    input  logic                  mask_empty,
    output logic [DW-1:0]         mask
);

    localparam int CW = $clog2(DW);

    logic [DW-1:0] ge_beg;
    logic [DW-1:0] le_end;
    logic          no_wrap;

    // bit i sits at big-endian position DW-1-i
    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam logic [CW-1:0] POS = CW'(DW - 1 - i);
        assign ge_beg[i] = (POS >= mask_beg);
        assign le_end[i] = (POS <= mask_end);
    end

    assign no_wrap = (mask_beg <= mask_end);

    always_comb begin
        if (mask_empty)
            mask = '0;
        else if (no_wrap)
            mask = ge_beg & le_end;
        else
            mask = ge_beg | le_end;
    end

endmodule

// File: rtl/rms_merge.sv
module rms_merge
    import rms_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] rot,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] op_ins,
    input  op_kind_e      kind,
    input  logic          word_lane,
    input  logic          src_sign,
    output logic [DW-1:0] res,
    output logic          carry
);

    localparam int HW = DW / 2;
    localparam logic [DW-1:0] LOW_LANE = {{HW{1'b0}}, {HW{1'b1}}};

    logic [DW-1:0] fill;
    logic [DW-1:0] lost;

    always_comb begin
        unique case (kind)
            OPK_ROTMASK: fill = op_ins;
            OPK_SRA:     fill = {DW{src_sign}};
            default:     fill = '0;
        endcase
    end

    // bits rotated out of the kept window; word forms only look at the low lane
    assign lost  = rot & ~mask & (word_lane ? LOW_LANE : {DW{1'b1}});
    assign res   = (rot & mask) | (fill & ~mask);
    assign carry = (kind == OPK_SRA) && src_sign && (|lost);

endmodule

// File: rtl/rms_unit.sv
module rms_unit
    import rms_pkg::*;
#(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       op_src,
    input  logic [DW-1:0]       op_ins,
    input  logic [$clog2(DW):0] shamt,
    input  logic [IW-1:0]       insn_word,
    input  logic                mode_word,
    input  logic                mode_right,
    input  logic                mode_arith,
    input  logic                clr_msb_en,
    input  logic                clr_lsb_en,
    input  logic                sext_src,
    output logic [DW-1:0]       result,
    output logic                carry_out
);

    localparam int CW = $clog2(DW);
    localparam int HW = DW / 2;

    op_kind_e      kind;
    src_sel_e      src_sel;
    logic [CW-1:0] rot_amt;
    logic [CW-1:0] mask_beg;
    logic [CW-1:0] mask_end;
    logic          mask_empty;
    logic          word_lane;
    logic          src_sign;
    logic [DW-1:0] rot_in;
    logic [DW-1:0] rot_out;
    logic [DW-1:0] mask;
    logic [DW-1:0] res_d;
    logic          carry_d;

    rms_decode #(.DW(DW), .IW(IW)) u_decode (
        .shamt      (shamt),
        .insn_word  (insn_word),
        .mode_word  (mode_word),
        .mode_right (mode_right),
        .mode_arith (mode_arith),
        .clr_msb_en (clr_msb_en),
        .clr_lsb_en (clr_lsb_en),
        .sext_src   (sext_src),
        .kind       (kind),
        .src_sel    (src_sel),
        .rot_amt    (rot_amt),
        .mask_beg   (mask_beg),
        .mask_end   (mask_end),
        .mask_empty (mask_empty),
        .word_lane  (word_lane)
    );

    always_comb begin
        unique case (src_sel)
            SRC_DUPWORD:  rot_in = {op_src[HW-1:0], op_src[HW-1:0]};
            SRC_SEXTWORD: rot_in = {{HW{op_src[HW-1]}}, op_src[HW-1:0]};
            default:      rot_in = op_src;
        endcase
    end

    assign src_sign = word_lane ? op_src[HW-1] : op_src[DW-1];

    rms_rotl #(.DW(DW)) u_rotl (
        .din  (rot_in),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    rms_maskgen #(.DW(DW)) u_maskgen (
        .mask_beg   (mask_beg),
        .mask_end   (mask_end),
        .mask_empty (mask_empty),
        .mask       (mask)
    );

    rms_merge #(.DW(DW)) u_merge (
        .rot       (rot_out),
        .mask      (mask),
        .op_ins    (op_ins),
        .kind      (kind),
        .word_lane (word_lane),
        .src_sign  (src_sign),
        .res       (res_d),
        .carry     (carry_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            result    <= res_d;
            carry_out <= carry_d;
        end
    end

endmodule

// File: rtl/rms_unit_chk.sv
module rms_unit_chk #(
    parameter int DW = 64,
    parameter int IW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DW-1:0]       op_src,
    input logic [DW-1:0]       op_ins,
    input logic [$clog2(DW):0] shamt,
    input logic [IW-1:0]       insn_word,
    input logic                mode_word,
    input logic                mode_right,
    input logic                mode_arith,
    input logic                clr_msb_en,
    input logic                clr_lsb_en,
    input logic                sext_src,
    input logic [DW-1:0]       result,
    input logic                carry_out
);

    localparam int CW = $clog2(DW);
    localparam int SW = CW + 1;
    localparam int HW = DW / 2;

    logic plain_shift;
    assign plain_shift = !sext_src && !clr_msb_en && !clr_lsb_en;

    AST_DW_SHL_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_shift && !mode_arith && !mode_right && !mode_word && shamt[SW-1]) |=> (result == '0)); // R6

    AST_WD_SHR_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_shift && !mode_arith && mode_right && mode_word && shamt[CW-1]) |=> (result == '0)); // R7

    AST_SRA_DW_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_shift && mode_arith && !mode_word && shamt[SW-1]) |=> (result == {DW{$past(op_src[DW-1])}})); // R8

    AST_NO_CARRY_NONARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (!plain_shift || !mode_arith) |=> !carry_out); // R9

    AST_NO_CARRY_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_shift && mode_arith && !(mode_word ? op_src[HW-1] : op_src[DW-1])) |=> !carry_out); // R9

    AST_SEXT_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (sext_src && shamt[CW-1:0] == '0) |=> (result == {{HW{$past(op_src[HW-1])}}, $past(op_src[HW-1:0])})); // R10

    AST_WORD_MASK_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sext_src && mode_word && clr_msb_en && clr_lsb_en && op_ins == '0
         && insn_word[2*CW-2:CW] <= insn_word[CW-1:1]) |=> (result[DW-1:HW] == '0)); // R2

endmodule

bind rms_unit rms_unit_chk #(.DW(DW), .IW(IW)) u_rms_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_src     (op_src),
    .op_ins     (op_ins),
    .shamt      (shamt),
    .insn_word  (insn_word),
    .mode_word  (mode_word),
    .mode_right (mode_right),
    .mode_arith (mode_arith),
    .clr_msb_en (clr_msb_en),
    .clr_lsb_en (clr_lsb_en),
    .sext_src   (sext_src),
    .result     (result),
    .carry_out  (carry_out)
);

// File: tb/tb_rms_unit.sv
`timescale 1ns/100ps
module tb_rms_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_src = '0;
    logic [63:0] op_ins = '0;
    logic [6:0]  shamt = '0;
    logic [31:0] insn_word = '0;
    logic        mode_word = 1'b0;
    logic        mode_right = 1'b0;
    logic        mode_arith = 1'b0;
    logic        clr_msb_en = 1'b0;
    logic        clr_lsb_en = 1'b0;
    logic        sext_src = 1'b0;
    logic [63:0] result;
    logic        carry_out;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [64:0] q_val [$];
    string       q_req [$];

    always #2.5 clk = ~clk;

    rms_unit dut (
        .clk(clk), .rst_n(rst_n), .op_src(op_src), .op_ins(op_ins),
        .shamt(shamt), .insn_word(insn_word), .mode_word(mode_word),
        .mode_right(mode_right), .mode_arith(mode_arith),
        .clr_msb_en(clr_msb_en), .clr_lsb_en(clr_lsb_en), .sext_src(sext_src),
        .result(result), .carry_out(carry_out)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rotl(logic [63:0] x, int n);
        if (n == 0) return x;
        return (x << n) | (x >> (64 - n));
    endfunction

    function automatic logic [63:0] be_mask(int b, int e);
        logic [63:0] m;
        for (int p = 0; p < 64; p++)
            m[63 - p] = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
        return m;
    endfunction

    function automatic logic [64:0] model(logic [63:0] s, logic [63:0] ins, logic [6:0] sh,
                                         logic [31:0] iw, bit w, bit r, bit a, bit cl, bit cr, bit sx);
        logic [63:0] res, rt, m, v;
        logic        cy;
        logic signed [31:0] s32;
        logic signed [63:0] s64;
        logic [31:0] t32;
        int n6, n7, f, mb, me;
        n6 = int'(sh[5:0]);
        n7 = int'(sh);
        cy = 1'b0;
        if (sx) begin
            v = {{32{s[31]}}, s[31:0]};
            res = v << n6;
        end else if (cl || cr) begin
            if (w) begin
                rt = rotl({s[31:0], s[31:0]}, n6 % 32);
                mb = cl ? 32 + int'(iw[10:6]) : 32;
                me = cr ? 32 + int'(iw[5:1]) : 63;
            end else begin
                rt = rotl(s, n6);
                f  = int'({iw[5], iw[10:6]});
                mb = cl ? f : 0;
                me = cr ? (cl ? 63 - n6 : f) : 63;
            end
            m = be_mask(mb, me);
            res = (rt & m) | (ins & ~m);
        end else if (a) begin
            if (w) begin
                s32 = s[31:0];
                if (n6 >= 32) begin
                    t32 = {32{s[31]}};
                    cy = s[31] && (s[31:0] != 0);
                end else begin
                    t32 = s32 >>> n6;
                    cy = s[31] && ((s[31:0] & ((32'd1 << n6) - 32'd1)) != 0);
                end
                res = {{32{t32[31]}}, t32};
            end else begin
                s64 = s;
                if (n7 >= 64) begin
                    res = {64{s[63]}};
                    cy = s[63] && (s != 0);
                end else begin
                    res = s64 >>> n7;
                    cy = s[63] && ((s & ((64'd1 << n7) - 64'd1)) != 0);
                end
            end
        end else if (r) begin
            if (w) res = (n6 >= 32) ? 64'd0 : {32'd0, s[31:0] >> n6};
            else   res = (n7 >= 64) ? 64'd0 : s >> n7;
        end else begin
            if (w) begin
                t32 = s[31:0] << n6;
                res = (n6 >= 32) ? 64'd0 : {32'd0, t32};
            end else begin
                res = (n7 >= 64) ? 64'd0 : s << n7;
            end
        end
        return {cy, res};
    endfunction

    function automatic logic [31:0] iw_word(int b, int e);
        return {21'd0, 5'(b), 5'(e), 1'b0};
    endfunction

    function automatic logic [31:0] iw_dw(int f);
        logic [5:0] x;
        x = 6'(f);
        return {21'd0, x[4:0], x[5], 5'd0};
    endfunction

    task automatic drive(string req, logic [63:0] s, logic [63:0] ins, logic [6:0] sh, logic [31:0] iw,
                         bit w, bit r, bit a, bit cl, bit cr, bit sx);
        @(negedge clk);
        op_src = s; op_ins = ins; shamt = sh; insn_word = iw;
        mode_word = w; mode_right = r; mode_arith = a;
        clr_msb_en = cl; clr_lsb_en = cr; sext_src = sx;
        q_val.push_back(model(s, ins, sh, iw, w, r, a, cl, cr, sx));
        q_req.push_back(req);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // monitor: each item driven before an edge is checked just after it
    initial begin
        logic [64:0] e;
        string rq;
        forever begin
            @(posedge clk);
            #1;
            if (q_val.size() > 0) begin
                e  = q_val.pop_front();
                rq = q_req.pop_front();
                check(rq, "result", result, e[63:0]);
                check(rq, "carry", {63'd0, carry_out}, {63'd0, e[64]});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    localparam logic [63:0] NEG = 64'hF000_0000_8000_0001;
    localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

    initial begin
        op_src = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset result", result, 64'd0);
        check("R1", "reset carry", {63'd0, carry_out}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 latency is exercised by every scoreboard item below
        // R2 word rotate under mask, plain and wrapping
        drive("R2", PAT, 0, 7'd8, iw_word(0, 31), 1, 0, 0, 1, 1, 0);
        drive("R2", PAT, 0, 7'd4, iw_word(28, 3), 1, 0, 0, 1, 1, 0);
        drive("R2", PAT, 0, 7'd63, iw_word(5, 5), 1, 0, 0, 1, 1, 0);
        // R3 insert
        drive("R3", PAT, 64'hAAAA_5555_AAAA_5555, 7'd12, iw_word(8, 19), 1, 0, 0, 1, 1, 0);
        drive("R3", PAT, 64'hDEAD_BEEF_0BAD_F00D, 7'd20, iw_dw(10), 0, 0, 0, 1, 1, 0);
        // R4 one-sided doubleword masks
        drive("R4", PAT, 0, 7'd16, iw_dw(40), 0, 0, 0, 1, 0, 0);
        drive("R4", PAT, 0, 7'd16, iw_dw(40), 0, 0, 0, 0, 1, 0);
        drive("R4", PAT, 0, 7'h45, iw_dw(0), 0, 0, 0, 1, 0, 0);
        // R5 both clears, wrapping
        drive("R5", PAT, 0, 7'd8, iw_dw(60), 0, 0, 0, 1, 1, 0);
        drive("R5", PAT, 64'h1111_2222_3333_4444, 7'd3, iw_dw(2), 0, 0, 0, 1, 1, 0);
        // R6 logical left bounds
        drive("R6", PAT, 0, 7'd31, 0, 1, 0, 0, 0, 0, 0);
        drive("R6", PAT, 0, 7'd32, 0, 1, 0, 0, 0, 0, 0);
        drive("R6", PAT, 0, 7'h40, 0, 1, 0, 0, 0, 0, 0);
        drive("R6", PAT, 0, 7'd63, 0, 0, 0, 0, 0, 0, 0);
        drive("R6", PAT, 0, 7'd64, 0, 0, 0, 0, 0, 0, 0);
        drive("R6", PAT, 0, 7'd127, 0, 0, 0, 0, 0, 0, 0);
        // R7 logical right bounds
        drive("R7", NEG, 0, 7'd1, 0, 1, 1, 0, 0, 0, 0);
        drive("R7", NEG, 0, 7'd32, 0, 1, 1, 0, 0, 0, 0);
        drive("R7", NEG, 0, 7'd63, 0, 0, 1, 0, 0, 0, 0);
        drive("R7", NEG, 0, 7'd64, 0, 0, 1, 0, 0, 0, 0);
        // R8 arithmetic right
        drive("R8", NEG, 0, 7'd0, 0, 1, 1, 1, 0, 0, 0);
        drive("R8", NEG, 0, 7'd31, 0, 1, 1, 1, 0, 0, 0);
        drive("R8", NEG, 0, 7'd32, 0, 1, 1, 1, 0, 0, 0);
        drive("R8", PAT, 0, 7'd40, 0, 1, 1, 1, 0, 0, 0);
        drive("R8", NEG, 0, 7'd63, 0, 0, 1, 1, 0, 0, 0);
        drive("R8", NEG, 0, 7'd100, 0, 0, 1, 1, 0, 0, 0);
        // R9 carry
        drive("R9", 64'h0000_0000_8000_0000, 0, 7'd4, 0, 1, 1, 1, 0, 0, 0);
        drive("R9", 64'h0000_0000_8000_0010, 0, 7'd5, 0, 1, 1, 1, 0, 0, 0);
        drive("R9", 64'h8000_0000_0000_0000, 0, 7'd64, 0, 0, 1, 1, 0, 0, 0);
        drive("R9", 64'h7FFF_FFFF_FFFF_FFFF, 0, 7'd8, 0, 0, 1, 1, 0, 0, 0);
        drive("R9", NEG, 0, 7'd4, 0, 0, 1, 0, 0, 0, 0);
        // R10 sign-extend shift, high count bit ignored
        drive("R10", NEG, 0, 7'd0, 0, 0, 0, 0, 0, 0, 1);
        drive("R10", NEG, 0, 7'h45, 0, 1, 1, 1, 0, 0, 1);
        drive("R10", PAT, 0, 7'd63, 0, 0, 0, 0, 0, 0, 1);
        // R11 insert operand ignored outside rotate-with-mask
        drive("R11", PAT, 64'hFFFF_FFFF_FFFF_FFFF, 7'd70, 0, 0, 0, 0, 0, 0, 0);
        drive("R11", PAT, 64'hFFFF_FFFF_FFFF_FFFF, 7'd9, 0, 1, 1, 0, 0, 0, 0);
        drive("R11", NEG, 64'h5555_5555_5555_5555, 7'd9, 0, 0, 1, 1, 0, 0, 0);
        drive("R11", NEG, 64'hFFFF_FFFF_FFFF_FFFF, 7'd7, 0, 0, 0, 0, 0, 0, 1);

        // random sweeps per mode
        for (int i = 0; i < 40; i++) begin
            drive("R2", rnd64(), 0, 7'($urandom), 32'($urandom) & 32'h7FE, 1, 0, 0, 1, 1, 0);
            drive("R3", rnd64(), rnd64(), 7'($urandom), 32'($urandom) & 32'h7FE, 1, 0, 0, 1, 1, 0);
            drive("R4", rnd64(), 0, 7'($urandom), 32'($urandom) & 32'h7FE, 0, 0, 0, 1, 0, 0);
            drive("R4", rnd64(), 0, 7'($urandom), 32'($urandom) & 32'h7FE, 0, 0, 0, 0, 1, 0);
            drive("R5", rnd64(), rnd64(), 7'($urandom), 32'($urandom) & 32'h7FE, 0, 0, 0, 1, 1, 0);
            drive("R6", rnd64(), 0, 7'($urandom), 0, 1'($urandom), 0, 0, 0, 0, 0);
            drive("R7", rnd64(), 0, 7'($urandom), 0, 1'($urandom), 1, 0, 0, 0, 0);
            drive("R8", rnd64(), 0, 7'($urandom), 0, 1'($urandom), 1, 1, 0, 0, 0);
            drive("R10", rnd64(), 0, 7'($urandom), 0, 0, 0, 0, 0, 0, 1);
        end

        repeat (4) @(posedge clk);
        #1;
        finish_run();
    end

endmodule